// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the two sleep states of a small 8-bit microcontroller core. Software writes a request strobe that carries an idle bit and a power-down bit. The block then moves the core between running, idle and power-down. It also decides which event wakes each state.

Idle gates only the CPU clock. Peripheral clocks and the oscillator keep running, and any enabled pending interrupt wakes the core. Power-down removes every clock and drops the oscillator enable. Only a hardware reset, or an external interrupt level, can end it. The external interrupt must have been enabled and set to level mode when the core entered power-down. After such a wake, the oscillator runs for a fixed number of stabilisation cycles before the CPU clock returns, and the first interrupt fetch is held back during that time.

A hardware reset that ends idle lets the core run for two machine cycles with internal RAM writes blocked before the reset takes over. Port writes stay allowed in that window. A reset that ends power-down returns straight to running and asks for a special-register reinitialisation. In both sleep states the block forces the address-latch strobe and the program-store strobe, and it sets the float, address and hold controls of the port drivers. RAM and special-register storage sit outside this block. The block keeps no copy of their contents.

States: RUN, IDLE, PDOWN, OSCWAIT (oscillator stabilisation), RSTWIN (reset window after idle). Transitions:
- RUN to PDOWN on a request write with the power-down bit set, whatever the idle bit holds.
- RUN to IDLE on a request write with only the idle bit set.
- IDLE to RSTWIN on a hardware reset.
- IDLE to RUN on a pending interrupt.
- PDOWN to RUN on a hardware reset.
- PDOWN to OSCWAIT on an armed external interrupt level.
- OSCWAIT to RUN on a hardware reset or when the stabilisation count ends.
- RSTWIN to RUN when the window count ends.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: After `rst_n` is released the block is running. `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1. `irq_hold`, `ram_wr_inhibit`, `ale_force`, `psen_force`, `p0_float`, `p2_addr_sel` and `port_hold` are 0.
- R2: A `req_wr` cycle with `req_idle`=1 and `req_pd`=0 causes, from the next cycle, `cpu_clk_en`=0 with `periph_clk_en`=1 and `osc_en`=1.
- R3: In idle, `irq_pending`=1 brings `cpu_clk_en` back to 1 on the next cycle.
- R4: A `req_wr` cycle with `req_pd`=1 causes, from the next cycle, `cpu_clk_en`, `periph_clk_en` and `osc_en` all 0. This holds also when `req_idle`=1 in the same write: power-down has priority.
- R5: Power-down ends only by `hw_reset` or by `ext_irq_level`=1. The level wake works only if `ext_irq_en`=1 and `ext_irq_lvl_mode`=1 were sampled in the entry cycle. `irq_pending` has no effect in power-down. An edge configuration (`ext_irq_lvl_mode`=0) at entry never wakes it, even if the mode is changed during power-down.
- R6: `osc_en` returns to 1 in the cycle after the wake level is sampled. `cpu_clk_en` then stays 0, with `irq_hold`=1, for exactly STAB_CYC cycles before returning to 1.
- R7: `hw_reset` in idle opens a window of 2×MC_CLKS cycles. In that window `cpu_clk_en`=1 and `ram_wr_inhibit`=1, and no port-side inhibit exists. Reset wins over an `irq_pending` in the same cycle.
- R8: `hw_reset` in power-down or during stabilisation raises `sfr_reinit` in that cycle. On the next cycle the block is running with `ram_wr_inhibit`=0. Reset wins over a wake level in the same cycle.
- R9: In idle, `ale_force`/`psen_force` are 1 with `ale_level`/`psen_level`=1. In power-down and stabilisation they are forced with level 0. While running they are not forced.
- R10: In any sleep state `port_hold`=1. With `ext_prog`=1, `p0_float`=1 in both states and `p2_addr_sel`=1 in idle only (0 means port 2 holds data). With `ext_prog`=0 both are 0.
- R11: `req_clear` is 1 for exactly the one cycle in which idle or power-down is left, by any cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hw_reset | input | 1 | Synchronised hardware reset pin level |
| req_wr | input | 1 | Strobe: software writes the request bits |
| req_idle | input | 1 | Idle request bit |
| req_pd | input | 1 | Power-down request bit |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| ext_irq_level | input | 1 | External interrupt pin active |
| ext_irq_en | input | 1 | External interrupt enabled |
| ext_irq_lvl_mode | input | 1 | 1 = level-sensitive, 0 = edge-sensitive |
| ext_prog | input | 1 | Core fetches from external program memory |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| irq_hold | output | 1 | Holds back the first interrupt fetch |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| sfr_reinit | output | 1 | Reinitialise special registers |
| req_clear | output | 1 | Clears both request bits |
| ale_force | output | 1 | Override the address-latch strobe |
| ale_level | output | 1 | Forced address-latch level |
| psen_force | output | 1 | Override the program-store strobe |
| psen_level | output | 1 | Forced program-store level |
| p0_float | output | 1 | Port 0 drivers float |
| p2_addr_sel | output | 1 | Port 2 drives address (1) or data (0) |
| port_hold | output | 1 | Port drivers hold their last data |

## Verification
A wake event and a hardware reset can arrive in the same cycle. This can happen in idle with `irq_pending`, or in power-down with `ext_irq_level`. The bench raises both inputs together.

In idle it judges that the reset window wins: `ram_wr_inhibit` stays high for the full window instead of a plain return to running. In power-down it judges that `sfr_reinit` rises and the block returns to running at once, with no stabilisation wait. A request write with both bits set is also checked, to show that power-down beats idle.

// File: rtl/lp_sleep_pkg.sv
package lp_sleep_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_PDOWN,
        ST_OSCWAIT,
        ST_RSTWIN
    } lp_state_t;

    typedef enum logic [1:0] {
        PM_RUN,
        PM_IDLE,
        PM_PD
    } pin_mode_t;

endpackage

// File: rtl/lp_delay_cnt.sv
module lp_delay_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Counter restarts from zero whenever run drops.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/lp_pin_ctrl.sv
module lp_pin_ctrl
    import lp_sleep_pkg::*;
(
    input  pin_mode_t mode,
    input  logic      ext_prog,
    output logic      ale_force,
    output logic      ale_level,
    output logic      psen_force,
    output logic      psen_level,
    output logic      p0_float,
    output logic      p2_addr_sel,
    output logic      port_hold
);
    always_comb begin
        ale_force   = 1'b0;
        ale_level   = 1'b0;
        psen_force  = 1'b0;
        psen_level  = 1'b0;
        p0_float    = 1'b0;
        p2_addr_sel = 1'b0;
        port_hold   = 1'b0;
        unique case (mode)
            PM_IDLE: begin
                ale_force   = 1'b1;
                ale_level   = 1'b1;
                psen_force  = 1'b1;
                psen_level  = 1'b1;
                p0_float    = ext_prog;
                p2_addr_sel = ext_prog;
                port_hold   = 1'b1;
            end
            PM_PD: begin
                ale_force   = 1'b1;
                psen_force  = 1'b1;
                p0_float    = ext_prog;
                port_hold   = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl
    import lp_sleep_pkg::*;
#(
    parameter int MC_CLKS  = 12,
    parameter int HOLD_MC  = 2,
    parameter int STAB_CYC = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_reset,
    input  logic req_wr,
    input  logic req_idle,
    input  logic req_pd,
    input  logic irq_pending,
    input  logic ext_irq_level,
    input  logic ext_irq_en,
    input  logic ext_irq_lvl_mode,
    input  logic ext_prog,
    output logic cpu_clk_en,
    output logic periph_clk_en,
    output logic osc_en,
    output logic irq_hold,
    output logic ram_wr_inhibit,
    output logic sfr_reinit,
    output logic req_clear,
    output logic ale_force,
    output logic ale_level,
    output logic psen_force,
    output logic psen_level,
    output logic p0_float,
    output logic p2_addr_sel,
    output logic port_hold
);
    localparam int WIN_CYC = MC_CLKS * HOLD_MC;

    lp_state_t state, nxt;
    pin_mode_t pin_mode;
    logic      wake_armed;
    logic      stab_done, win_done;

    lp_delay_cnt #(.LIMIT(STAB_CYC)) u_stab_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_OSCWAIT),
        .done  (stab_done)
    );

    lp_delay_cnt #(.LIMIT(WIN_CYC)) u_win_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_RSTWIN),
        .done  (win_done)
    );

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (req_wr && req_pd)        nxt = ST_PDOWN;
                else if (req_wr && req_idle) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (hw_reset)         nxt = ST_RSTWIN;
                else if (irq_pending) nxt = ST_RUN;
            end
            ST_PDOWN: begin
                if (hw_reset)                         nxt = ST_RUN;
                else if (wake_armed && ext_irq_level) nxt = ST_OSCWAIT;
            end
            ST_OSCWAIT: begin
                if (hw_reset || stab_done) nxt = ST_RUN;
            end
            ST_RSTWIN: begin
                if (win_done) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Wake configuration captured in the entry cycle of power-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_armed <= 1'b0;
        end else if (state == ST_RUN && nxt == ST_PDOWN) begin
            wake_armed <= ext_irq_en && ext_irq_lvl_mode;
        end
    end

    // Outputs
    always_comb begin
        cpu_clk_en     = 1'b1;
        periph_clk_en  = 1'b1;
        osc_en         = 1'b1;
        irq_hold       = 1'b0;
        ram_wr_inhibit = 1'b0;
        pin_mode       = PM_RUN;
        unique case (state)
            ST_IDLE: begin
                cpu_clk_en = 1'b0;
                pin_mode   = PM_IDLE;
            end
            ST_PDOWN: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                osc_en        = 1'b0;
                irq_hold      = 1'b1;
                pin_mode      = PM_PD;
            end
            ST_OSCWAIT: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                irq_hold      = 1'b1;
                pin_mode      = PM_PD;
            end
            ST_RSTWIN: begin
                ram_wr_inhibit = 1'b1;
            end
            default: begin
            end
        endcase
        req_clear  = (state == ST_IDLE || state == ST_PDOWN) && (nxt != state);
        sfr_reinit = (state == ST_PDOWN || state == ST_OSCWAIT) && hw_reset;
    end

    lp_pin_ctrl u_pins (
        .mode        (pin_mode),
        .ext_prog    (ext_prog),
        .ale_force   (ale_force),
        .ale_level   (ale_level),
        .psen_force  (psen_force),
        .psen_level  (psen_level),
        .p0_float    (p0_float),
        .p2_addr_sel (p2_addr_sel),
        .port_hold   (port_hold)
    );
endmodule

// File: rtl/lp_sleep_ctrl_sva.sv
module lp_sleep_ctrl_sva (
    input logic clk,
    input logic rst_n,
    input logic hw_reset,
    input logic req_wr,
    input logic req_pd,
    input logic cpu_clk_en,
    input logic periph_clk_en,
    input logic osc_en,
    input logic irq_hold,
    input logic ram_wr_inhibit,
    input logic req_clear,
    input logic ale_force,
    input logic ale_level,
    input logic wake_armed
);
    assert_pd_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && periph_clk_en && osc_en && !ram_wr_inhibit && req_wr && req_pd)
        |=> !osc_en);

    assert_stab_before_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !hw_reset) |=> !cpu_clk_en);

    assert_unarmed_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !hw_reset && !wake_armed) |=> !osc_en);

    assert_window_runs_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_inhibit |-> cpu_clk_en);

    assert_low_strobe_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_force && !ale_level) |-> (!cpu_clk_en && irq_hold));

    assert_clear_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_clear |=> !req_clear);
endmodule

bind lp_sleep_ctrl lp_sleep_ctrl_sva u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_reset       (hw_reset),
    .req_wr         (req_wr),
    .req_pd         (req_pd),
    .cpu_clk_en     (cpu_clk_en),
    .periph_clk_en  (periph_clk_en),
    .osc_en         (osc_en),
    .irq_hold       (irq_hold),
    .ram_wr_inhibit (ram_wr_inhibit),
    .req_clear      (req_clear),
    .ale_force      (ale_force),
    .ale_level      (ale_level),
    .wake_armed     (wake_armed)
);

// File: tb/lp_sleep_ctrl_test.sv
`timescale 1ns/100ps
module lp_sleep_ctrl_test;
    localparam int MC  = 3;
    localparam int HMC = 2;
    localparam int WIN = MC * HMC;
    localparam int STB = 20;

    // Vector fields: [6] ext_prog, [5] 1=power-down 0=idle,
    // [4] ale_level, [3] psen_level, [2] p0_float, [1] p2_addr_sel, [0] port_hold
    localparam logic [6:0] VEC [4] = '{
        7'b0_0_11_001,
        7'b1_0_11_111,
        7'b0_1_00_001,
        7'b1_1_00_101
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_reset = 0, req_wr = 0, req_idle = 0, req_pd = 0, irq_pending = 0;
    logic ext_irq_level = 0, ext_irq_en = 0, ext_irq_lvl_mode = 0, ext_prog = 0;
    logic cpu_clk_en, periph_clk_en, osc_en, irq_hold, ram_wr_inhibit, sfr_reinit, req_clear;
    logic ale_force, ale_level, psen_force, psen_level, p0_float, p2_addr_sel, port_hold;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lp_sleep_ctrl #(.MC_CLKS(MC), .HOLD_MC(HMC), .STAB_CYC(STB)) uut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic enter(input bit pd, input bit idl);
        req_wr = 1; req_pd = pd; req_idle = idl;
        step();
        req_wr = 0; req_pd = 0; req_idle = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        #12;
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);
        chk("R1 overrides", {irq_hold, ram_wr_inhibit, ale_force, psen_force, p0_float, p2_addr_sel, port_hold}, 7'b0);

        // Table walk: entry, pin overrides, wake
        ext_irq_en = 1; ext_irq_lvl_mode = 1;
        for (int i = 0; i < 4; i++) begin
            ext_prog = VEC[i][6];
            enter(VEC[i][5], !VEC[i][5]);
            chk("R9 forced", {ale_force, psen_force}, 2'b11);
            chk("R9 levels", {ale_level, psen_level}, VEC[i][4:3]);
            chk("R10 ports", {p0_float, p2_addr_sel, port_hold}, VEC[i][2:0]);
            if (!VEC[i][5]) begin
                chk("R2 idle clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b011);
                irq_pending = 1;
                #1;
                chk("R11 clear on idle wake", req_clear, 1);
                step();
                irq_pending = 0;
                chk("R3 idle wake", cpu_clk_en, 1);
                chk("R11 clear single", req_clear, 0);
            end else begin
                chk("R4 pd clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b000);
                ext_irq_level = 1;
                #1;
                chk("R11 clear on pd wake", req_clear, 1);
                step();
                ext_irq_level = 0;
                chk("R6 osc back", {osc_en, cpu_clk_en, irq_hold}, 3'b101);
                chk("R9 low during stab", {ale_force, ale_level}, 2'b10);
                for (int k = 0; k < STB - 1; k++) step();
                chk("R6 still held", cpu_clk_en, 0);
                step();
                chk("R6 released", {cpu_clk_en, irq_hold}, 2'b10);
            end
            chk("R9 released", {ale_force, psen_force, port_hold}, 3'b000);
        end

        // R4 priority with both bits
        ext_prog = 0;
        enter(1, 1);
        chk("R4 both bits", {osc_en, periph_clk_en}, 2'b00);
        // R8 reset with wake level in same cycle
        hw_reset = 1; ext_irq_level = 1;
        #1;
        chk("R8 sfr_reinit", sfr_reinit, 1);
        chk("R11 clear on reset", req_clear, 1);
        step();
        hw_reset = 0; ext_irq_level = 0;
        chk("R8 back running", {cpu_clk_en, osc_en, ram_wr_inhibit}, 3'b110);

        // R5 edge configuration at entry never wakes
        ext_irq_lvl_mode = 0;
        enter(1, 0);
        ext_irq_level = 1; irq_pending = 1;
        for (int k = 0; k < 5; k++) step();
        chk("R5 edge and pending ignored", {osc_en, cpu_clk_en}, 2'b00);
        ext_irq_lvl_mode = 1;
        for (int k = 0; k < 3; k++) step();
        chk("R5 late mode change ignored", osc_en, 0);
        ext_irq_level = 0; irq_pending = 0;
        hw_reset = 1;
        step();
        hw_reset = 0;
        chk("R8 exit by reset", cpu_clk_en, 1);

        // R8 reset during stabilisation
        enter(1, 0);
        ext_irq_level = 1;
        step();
        ext_irq_level = 0;
        hw_reset = 1;
        #1;
        chk("R8 reinit in stab", sfr_reinit, 1);
        step();
        hw_reset = 0;
        chk("R8 stab cut short", cpu_clk_en, 1);

        // R7 reset in idle, with interrupt same cycle
        enter(0, 1);
        hw_reset = 1; irq_pending = 1;
        step();
        hw_reset = 0; irq_pending = 0;
        chk("R7 window open", {cpu_clk_en, ram_wr_inhibit}, 2'b11);
        for (int k = 0; k < WIN - 1; k++) step();
        chk("R7 window last cycle", ram_wr_inhibit, 1);
        step();
        chk("R7 window closed", {cpu_clk_en, ram_wr_inhibit}, 2'b10);

        done = 1;
        summary();
        $finish;
    end
endmodule